// File: doc/BRIEF.md
# IO Shift Register Unit

This block holds the input and output shift registers of one programmable IO state machine, together with a bit counter for each. The instruction decoder hands it one operation per cycle: an operation code, an 8-bit argument byte and a source word. The unit then shifts bits into the input register, shifts bits out of the output register, moves the input register into the receive FIFO, or loads the output register from the transmit FIFO. When automatic mode is enabled, it drains the input register once enough bits have arrived and refills the output register once enough bits have left. Both modes compare against a programmable threshold.

If an operation cannot complete because the receive FIFO is full or the transmit FIFO is empty, `stall` is raised in the same cycle. The sequencer then presents the same operation again on the next cycle. A stalled operation changes no state.

The FIFO handshakes and `stall` are decided combinationally in the cycle of the operation, and the FIFOs are expected to show their head word on the same cycle. Register contents and `out_bits` update at the clock edge that ends the operation. The direction flags, automatic-mode enables and thresholds are static configuration inputs.

Top module: `pio_shift_unit`

## Requirements
- R1: After a synchronous reset, `isr_value`, `osr_value` and `out_bits` are 0 and the input counter is 0. The output counter resets to 32, so the output register counts as empty.
- R2: Operation code 2 shifts n bits into the input register, where n is `op_arg[4:0]` and 0 means 32. With `in_shr`=1 the register shifts right and the low n bits of `src_data` enter at the MSB end.
- R3: With `in_shr`=0 the input register shifts left and the low n bits of `src_data` enter at the LSB end. The input counter adds n and saturates at 32.
- R4: Operation code 3 shifts n bits out of the output register. With `out_shr`=1, `out_bits` receives the n low bits and the register shifts right by n. With `out_shr`=0, `out_bits` receives the n high bits right-aligned and the register shifts left by n.
- R5: When `autopush_en` is set and an operation-2 shift brings the input counter to `push_thresh` or above (0 means 32), the shifted word is written to the receive FIFO in that cycle, and the register and counter clear. If `rx_full` is set, the operation stalls instead.
- R6: Operation code 4 with `op_arg[7]`=0 is a push. It writes the input register to the receive FIFO and clears the register and its counter. `op_arg[6]` is the threshold qualifier and `op_arg[5]` selects blocking.
- R7: A push with `op_arg[6]`=1 while the input counter is below `push_thresh` does nothing.
- R8: A push with `rx_full`=1 stalls if it is blocking. If it is non-blocking, it discards the data without writing the FIFO and still clears the register. `rx_push` is never raised while `rx_full` is set.
- R9: Operation code 4 with `op_arg[7]`=1 is a pull. It pops `tx_data` into the output register and clears the output counter. On an empty FIFO, a blocking pull stalls and a non-blocking pull loads `x_data` instead.
- R10: A pull with `op_arg[6]`=1 while the output counter is below `pull_thresh` (0 means 32) does nothing.
- R11: When `autopull_en` is set and the output counter is at `pull_thresh` or above, an operation 3 first pops `tx_data` in the same cycle and then shifts from the new word. If the FIFO is empty, it stalls.
- R12: Operation code 5 with `op_arg[7:5]`=6 loads `src_data` into the input register. With `op_arg[7:5]`=7 it loads the output register. Either way, the matching counter is set to 0.
- R13: While `stall` is high, no register changes and neither `rx_push` nor `tx_pop` is raised.
- R14: Other operation codes, and cycles with `op_valid` low, change nothing and raise no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation code |
| op_arg | input | 8 | Argument byte: count, qualifiers, MOV destination |
| src_data | input | 32 | Source word for shift-in and MOV |
| x_data | input | 32 | Scratch X value used by a non-blocking pull on an empty FIFO |
| in_shr | input | 1 | Input register shifts right when 1 |
| out_shr | input | 1 | Output register shifts right when 1 |
| autopush_en | input | 1 | Enable automatic push |
| autopull_en | input | 1 | Enable automatic pull |
| push_thresh | input | 5 | Push threshold, 0 means 32 |
| pull_thresh | input | 5 | Pull threshold, 0 means 32 |
| tx_empty | input | 1 | Transmit FIFO is empty |
| tx_data | input | 32 | Transmit FIFO head word |
| tx_pop | output | 1 | Pop the transmit FIFO |
| rx_full | input | 1 | Receive FIFO is full |
| rx_push | output | 1 | Write the receive FIFO |
| rx_data | output | 32 | Word written to the receive FIFO |
| stall | output | 1 | Operation cannot complete this cycle |
| out_bits | output | 32 | Bits produced by the last shift-out, right-aligned |
| isr_value | output | 32 | Input shift register contents |
| osr_value | output | 32 | Output shift register contents |

## Verification
Two pairs of functions meet in a single cycle. An automatic refill and the shift-out that follows it happen in the same cycle. An automatic push happens in the same cycle as the shift-in that triggers it.

The bench provokes the first case by presenting a shift-out once the output counter has reached the pull threshold. It then judges that `tx_pop` is high in that very cycle and that `out_bits` holds bits of the freshly popped word rather than the old register.

It provokes the second case by shifting in the bits that reach the push threshold. It checks that `rx_data` already contains the newly shifted bits and that the register reads zero afterwards. Both cases are repeated with the FIFO unable to serve, where a stall with frozen registers is expected.

// File: rtl/pio_shift_pkg.sv
`timescale 1ns/1ps
package pio_shift_pkg;
  typedef enum logic [2:0] {
    OPC_IN   = 3'd2,
    OPC_OUT  = 3'd3,
    OPC_XFER = 3'd4,
    OPC_MOV  = 3'd5
  } opc_e;

  localparam logic [2:0] MOV_TO_ISR = 3'd6;
  localparam logic [2:0] MOV_TO_OSR = 3'd7;
endpackage

// File: rtl/pio_isr_path.sv
`timescale 1ns/1ps
module pio_isr_path
  import pio_shift_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [7:0]   op_arg,
  input  logic [W-1:0] src_data,
  input  logic         in_shr,
  input  logic         autopush_en,
  input  logic [$clog2(W)-1:0] push_thresh,
  input  logic         rx_full,
  output logic         rx_push,
  output logic [W-1:0] rx_data,
  output logic         stall,
  output logic [W-1:0] isr_q
);
  localparam int CW = $clog2(W);

  logic [CW:0]   cnt_q;
  logic [CW:0]   amt, rsh, thr, cnt_sum;
  logic [CW+1:0] sum;
  logic [W-1:0]  lowmask, shifted;
  logic          is_in, is_push, is_mov, fire, skip;

  always_comb begin
    amt     = (op_arg[CW-1:0] == '0) ? (CW+1)'(W) : {1'b0, op_arg[CW-1:0]};
    thr     = (push_thresh == '0) ? (CW+1)'(W) : {1'b0, push_thresh};
    rsh     = (CW+1)'(W) - amt;
    lowmask = ~({W{1'b1}} << amt);
    shifted = in_shr ? ((isr_q >> amt) | (src_data << rsh))
                     : ((isr_q << amt) | (src_data & lowmask));
    sum     = {1'b0, cnt_q} + {1'b0, amt};
    cnt_sum = (sum > (CW+2)'(W)) ? (CW+1)'(W) : sum[CW:0];
    is_in   = op_valid && (op_code == OPC_IN);
    is_push = op_valid && (op_code == OPC_XFER) && !op_arg[7];
    is_mov  = op_valid && (op_code == OPC_MOV) && (op_arg[7:5] == MOV_TO_ISR);
    fire    = autopush_en && (cnt_sum >= thr);
    skip    = op_arg[6] && (cnt_q < thr);
    stall   = (is_in && fire && rx_full) ||
              (is_push && !skip && rx_full && op_arg[5]);
    rx_push = (is_in && fire && !rx_full) || (is_push && !skip && !rx_full);
    rx_data = is_in ? shifted : isr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= '0;
      cnt_q <= '0;
    end else if (is_mov) begin
      isr_q <= src_data;
      cnt_q <= '0;
    end else if (is_in && !stall) begin
      isr_q <= fire ? '0 : shifted;
      cnt_q <= fire ? '0 : cnt_sum;
    end else if (is_push && !skip && !stall) begin
      isr_q <= '0;
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/pio_osr_path.sv
`timescale 1ns/1ps
module pio_osr_path
  import pio_shift_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [7:0]   op_arg,
  input  logic [W-1:0] src_data,
  input  logic [W-1:0] x_data,
  input  logic         out_shr,
  input  logic         autopull_en,
  input  logic [$clog2(W)-1:0] pull_thresh,
  input  logic         tx_empty,
  input  logic [W-1:0] tx_data,
  output logic         tx_pop,
  output logic         stall,
  output logic [W-1:0] osr_q,
  output logic [W-1:0] out_bits
);
  localparam int CW = $clog2(W);

  logic [CW:0]   cnt_q, base_cnt;
  logic [CW:0]   amt, rsh, thr, cnt_sum;
  logic [CW+1:0] sum;
  logic [W-1:0]  lowmask, base, bits, nxt;
  logic          is_out, is_pull, is_mov, refill, skip;

  always_comb begin
    amt      = (op_arg[CW-1:0] == '0) ? (CW+1)'(W) : {1'b0, op_arg[CW-1:0]};
    thr      = (pull_thresh == '0) ? (CW+1)'(W) : {1'b0, pull_thresh};
    rsh      = (CW+1)'(W) - amt;
    lowmask  = ~({W{1'b1}} << amt);
    is_out   = op_valid && (op_code == OPC_OUT);
    is_pull  = op_valid && (op_code == OPC_XFER) && op_arg[7];
    is_mov   = op_valid && (op_code == OPC_MOV) && (op_arg[7:5] == MOV_TO_OSR);
    refill   = is_out && autopull_en && (cnt_q >= thr);
    skip     = op_arg[6] && (cnt_q < thr);
    base     = refill ? tx_data : osr_q;
    base_cnt = refill ? '0 : cnt_q;
    bits     = out_shr ? (base & lowmask) : (base >> rsh);
    nxt      = out_shr ? (base >> amt) : (base << amt);
    sum      = {1'b0, base_cnt} + {1'b0, amt};
    cnt_sum  = (sum > (CW+2)'(W)) ? (CW+1)'(W) : sum[CW:0];
    stall    = (refill && tx_empty) ||
               (is_pull && !skip && tx_empty && op_arg[5]);
    tx_pop   = (refill && !tx_empty) || (is_pull && !skip && !tx_empty);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      osr_q    <= '0;
      cnt_q    <= (CW+1)'(W);
      out_bits <= '0;
    end else if (is_mov) begin
      osr_q <= src_data;
      cnt_q <= '0;
    end else if (is_out && !stall) begin
      osr_q    <= nxt;
      cnt_q    <= cnt_sum;
      out_bits <= bits;
    end else if (is_pull && !skip && !stall) begin
      osr_q <= tx_empty ? x_data : tx_data;
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/pio_shift_unit.sv
`timescale 1ns/1ps
module pio_shift_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [7:0]   op_arg,
  input  logic [W-1:0] src_data,
  input  logic [W-1:0] x_data,
  input  logic         in_shr,
  input  logic         out_shr,
  input  logic         autopush_en,
  input  logic         autopull_en,
  input  logic [$clog2(W)-1:0] push_thresh,
  input  logic [$clog2(W)-1:0] pull_thresh,
  input  logic         tx_empty,
  input  logic [W-1:0] tx_data,
  output logic         tx_pop,
  input  logic         rx_full,
  output logic         rx_push,
  output logic [W-1:0] rx_data,
  output logic         stall,
  output logic [W-1:0] out_bits,
  output logic [W-1:0] isr_value,
  output logic [W-1:0] osr_value
);
  logic stall_in, stall_out;

  pio_isr_path #(.W(W)) u_isr (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_arg(op_arg), .src_data(src_data), .in_shr(in_shr),
    .autopush_en(autopush_en), .push_thresh(push_thresh),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
    .stall(stall_in), .isr_q(isr_value)
  );

  pio_osr_path #(.W(W)) u_osr (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_arg(op_arg), .src_data(src_data), .x_data(x_data),
    .out_shr(out_shr), .autopull_en(autopull_en),
    .pull_thresh(pull_thresh), .tx_empty(tx_empty), .tx_data(tx_data),
    .tx_pop(tx_pop), .stall(stall_out), .osr_q(osr_value),
    .out_bits(out_bits)
  );

  assign stall = stall_in | stall_out;
endmodule

// File: rtl/pio_shift_unit_chk.sv
`timescale 1ns/1ps
module pio_shift_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [2:0]   op_code,
  input logic [7:0]   op_arg,
  input logic [W-1:0] src_data,
  input logic         tx_empty,
  input logic         tx_pop,
  input logic         rx_full,
  input logic         rx_push,
  input logic         stall,
  input logic [W-1:0] isr_value,
  input logic [W-1:0] osr_value
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (isr_value == '0 && osr_value == '0));
  // R9
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> !tx_empty);
  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !rx_full);
  // R13
  stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> (!rx_push && !tx_pop));
  // R13
  stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(isr_value) && $stable(osr_value)));
  // R14
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> (!rx_push && !tx_pop && !stall));
  // R12
  mov_isr_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd5 && op_arg[7:5] == 3'd6)
      |=> (isr_value == $past(src_data)));
endmodule

bind pio_shift_unit pio_shift_unit_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .op_arg(op_arg), .src_data(src_data), .tx_empty(tx_empty),
  .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .stall(stall),
  .isr_value(isr_value), .osr_value(osr_value)
);

// File: tb/test_pio_shift_unit.sv
`timescale 1ns/1ps
module test_pio_shift_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [7:0] op_arg = '0;
  logic [31:0] src_data = '0, x_data = '0, tx_data = '0;
  logic in_shr = 1'b0, out_shr = 1'b0, autopush_en = 1'b0, autopull_en = 1'b0;
  logic [4:0] push_thresh = '0, pull_thresh = '0;
  logic tx_empty = 1'b1, rx_full = 1'b0;
  logic tx_pop, rx_push, stall;
  logic [31:0] rx_data, out_bits, isr_value, osr_value;

  pio_shift_unit i_pio_shift_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_arg(op_arg), .src_data(src_data), .x_data(x_data),
    .in_shr(in_shr), .out_shr(out_shr), .autopush_en(autopush_en),
    .autopull_en(autopull_en), .push_thresh(push_thresh),
    .pull_thresh(pull_thresh), .tx_empty(tx_empty), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push),
    .rx_data(rx_data), .stall(stall), .out_bits(out_bits),
    .isr_value(isr_value), .osr_value(osr_value)
  );

  int checks = 0;
  int fails = 0;
  logic c_push, c_pop, c_stall;
  logic [31:0] c_rxd;

  // {in_shr, arg, src, expected isr}, applied in order from an empty register
  localparam logic [72:0] VEC [6] = '{
    {1'b1, 8'h08, 32'h000000AB, 32'hAB000000},
    {1'b1, 8'h04, 32'h00000005, 32'h5AB00000},
    {1'b0, 8'h04, 32'hFFFFFFF3, 32'hAB000003},
    {1'b0, 8'h00, 32'h12345678, 32'h12345678},
    {1'b1, 8'h10, 32'h0000BEEF, 32'hBEEF1234},
    {1'b0, 8'h08, 32'h000000CD, 32'hEF1234CD}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] code, input logic [7:0] arg, input logic [31:0] src);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_arg = arg; src_data = src;
    #1;
    c_push = rx_push; c_pop = tx_pop; c_stall = stall; c_rxd = rx_data;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 isr", isr_value, 32'h0);
    chk("R1 osr", osr_value, 32'h0);
    chk("R1 out_bits", out_bits, 32'h0);
    chk("R1 stall", {31'b0, stall}, 32'h0);

    for (int i = 0; i < 6; i++) begin
      in_shr = VEC[i][72];
      op(3'd2, VEC[i][71:64], VEC[i][63:32]);
      chk(VEC[i][72] ? "R2 shift-in right" : "R3 shift-in left", isr_value, VEC[i][31:0]);
    end

    // R6 plain push
    op(3'd4, 8'h00, 32'h0);
    chk("R6 push strobe", {31'b0, c_push}, 32'h1);
    chk("R6 push data", c_rxd, 32'hEF1234CD);
    chk("R6 isr cleared", isr_value, 32'h0);

    // R7 qualified push below threshold
    push_thresh = 5'd8; in_shr = 1'b0;
    op(3'd2, 8'h04, 32'h0000000F);
    op(3'd4, 8'h40, 32'h0);
    chk("R7 no push", {31'b0, c_push}, 32'h0);
    chk("R7 isr kept", isr_value, 32'h0000000F);

    // R8 full FIFO
    rx_full = 1'b1;
    op(3'd4, 8'h20, 32'h0);
    chk("R8 blocking stall", {31'b0, c_stall}, 32'h1);
    chk("R8 no write", {31'b0, c_push}, 32'h0);
    chk("R8 isr held", isr_value, 32'h0000000F);
    op(3'd4, 8'h00, 32'h0);
    chk("R8 nonblocking no stall", {31'b0, c_stall}, 32'h0);
    chk("R8 nonblocking discard", {31'b0, c_push}, 32'h0);
    chk("R8 isr cleared", isr_value, 32'h0);
    rx_full = 1'b0;

    // R5 automatic push, same cycle as the shift that reaches the threshold
    autopush_en = 1'b1;
    op(3'd2, 8'h04, 32'h0000000A);
    chk("R5 below threshold", {31'b0, c_push}, 32'h0);
    op(3'd2, 8'h04, 32'h00000005);
    chk("R5 push strobe", {31'b0, c_push}, 32'h1);
    chk("R5 push data", c_rxd, 32'h000000A5);
    chk("R5 isr cleared", isr_value, 32'h0);
    rx_full = 1'b1;
    op(3'd2, 8'h04, 32'h00000001);
    op(3'd2, 8'h04, 32'h00000002);
    chk("R5 full stalls", {31'b0, c_stall}, 32'h1);
    chk("R13 isr frozen", isr_value, 32'h00000001);
    rx_full = 1'b0; autopush_en = 1'b0;

    // R12 moves
    op(3'd5, 8'hC0, 32'hDEADBEEF);
    chk("R12 mov isr", isr_value, 32'hDEADBEEF);
    op(3'd5, 8'hE0, 32'h8000000F);
    chk("R12 mov osr", osr_value, 32'h8000000F);

    // R4 shift-out both directions
    out_shr = 1'b1;
    op(3'd3, 8'h04, 32'h0);
    chk("R4 right bits", out_bits, 32'h0000000F);
    chk("R4 right osr", osr_value, 32'h08000000);
    out_shr = 1'b0;
    op(3'd3, 8'h08, 32'h0);
    chk("R4 left bits", out_bits, 32'h00000008);
    chk("R4 left osr", osr_value, 32'h00000000);

    // R9 pulls
    tx_empty = 1'b0; tx_data = 32'h13572468;
    op(3'd4, 8'hA0, 32'h0);
    chk("R9 pop", {31'b0, c_pop}, 32'h1);
    chk("R9 osr loaded", osr_value, 32'h13572468);
    tx_empty = 1'b1;
    op(3'd4, 8'hA0, 32'h0);
    chk("R9 blocking stall", {31'b0, c_stall}, 32'h1);
    chk("R13 osr frozen", osr_value, 32'h13572468);
    x_data = 32'hCAFEF00D;
    op(3'd4, 8'h80, 32'h0);
    chk("R9 nonblocking no stall", {31'b0, c_stall}, 32'h0);
    chk("R9 osr from x", osr_value, 32'hCAFEF00D);

    // R10 qualified pull below threshold
    pull_thresh = 5'd8; tx_empty = 1'b0; tx_data = 32'h11111111;
    op(3'd4, 8'hC0, 32'h0);
    chk("R10 no pop", {31'b0, c_pop}, 32'h0);
    chk("R10 osr kept", osr_value, 32'hCAFEF00D);

    // R11 automatic refill merged with the shift-out
    autopull_en = 1'b1; out_shr = 1'b1;
    op(3'd3, 8'h08, 32'h0);
    chk("R11 no refill below", {31'b0, c_pop}, 32'h0);
    chk("R11 bits old word", out_bits, 32'h0000000D);
    tx_data = 32'h87654321;
    op(3'd3, 8'h04, 32'h0);
    chk("R11 refill pop", {31'b0, c_pop}, 32'h1);
    chk("R11 bits new word", out_bits, 32'h00000001);
    chk("R11 osr new word", osr_value, 32'h08765432);
    tx_empty = 1'b1;
    op(3'd3, 8'h04, 32'h0);
    chk("R11 partial count", osr_value, 32'h00876543);
    op(3'd3, 8'h04, 32'h0);
    chk("R11 empty stall", {31'b0, c_stall}, 32'h1);
    chk("R13 no pop in stall", {31'b0, c_pop}, 32'h0);
    chk("R13 osr frozen out", osr_value, 32'h00876543);

    // R14 unused opcode
    op(3'd6, 8'hFF, 32'hFFFFFFFF);
    chk("R14 no handshake", {29'b0, c_stall, c_pop, c_push}, 32'h0);
    chk("R14 isr kept", isr_value, 32'hDEADBEEF);
    chk("R14 osr kept", osr_value, 32'h00876543);

    // R1/R11 reset leaves the output register empty: first shift-out refills
    do_reset();
    chk("R1 isr after run", isr_value, 32'h0);
    pull_thresh = 5'd0; tx_empty = 1'b0; tx_data = 32'hAABBCCDD;
    op(3'd3, 8'h08, 32'h0);
    chk("R11 refill after reset", {31'b0, c_pop}, 32'h1);
    chk("R11 bits after reset", out_bits, 32'h000000DD);
    chk("R11 osr after reset", osr_value, 32'h00AABBCC);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule